// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Generator

This block produces the serial clock and the four active-low chip-select lines of a serial flash master. It derives them from a faster reference clock. A transfer sequencer asks for a frame with a start pulse and asks for its end with a stop pulse. The block places the chip-select assertion and the serial clock edges according to its configuration, and it enforces the programmed gaps around each frame. In the cycle that each serial clock edge becomes visible, it raises a one-cycle strobe that tells the data path whether to shift out the next bit or to sample the incoming bit.

Configuration covers the following:
- a 4-bit baud field N, giving a serial clock of the reference clock divided by 2(N+1);
- clock polarity and clock phase;
- either a raw 4-bit chip-select field for an external decoder, or a device index converted to a one-hot active-low select;
- four 8-bit delays in reference cycles: lead, tail, inter-frame gap and device switch.

The hardware adds an extra serial clock period plus a few reference cycles to the tail and gap delays. Configuration is changed only while the enable input is low, and dropping enable aborts any frame at once.

Top module: `sclk_cs_gen`

## Requirements
- R1: Within a frame, successive SCLK transitions are exactly N+1 reference cycles apart, so the SCLK period is 2(N+1) cycles, where N is cfg_baud.
- R2: Whenever all chip selects are high, SCLK rests at the level of cfg_cpol. This holds from one cycle after reset or after a polarity change.
- R3: With cfg_cpha=0, sample_stb pulses with each leading SCLK transition (away from the idle level) and shift_stb pulses with each trailing transition. With cfg_cpha=1 the roles swap. A strobe lasts one cycle, appears in the same cycle as the new SCLK level, and never appears without a transition.
- R4: With cfg_decode=1, cs_n carries cfg_csel unchanged while a frame is active.
- R5: With cfg_decode=0, cs_n is all ones except bit k, which is low, where k is cfg_csel[1:0]. Device 0 gives 1110 and device 3 gives 0111.
- R6: The first SCLK transition comes cfg_lead+N+2 cycles after cs_n asserts.
- R7: cs_n deasserts cfg_tail+2(N+1)+3 cycles after the last SCLK transition.
- R8: idle rises cfg_gap+2(N+1) cycles after cs_n deasserts. With frm_start held high, the next assertion follows the deassertion by cfg_gap+2(N+1)+1 cycles.
- R9: A frame always holds a whole number of 8-bit units (16 SCLK transitions each). A stop request ends the frame after the unit in progress completes.
- R10: If the new select pattern differs from that of the previous frame, cs_n asserts cfg_swap+2 cycles after frm_start is sampled. Otherwise it asserts 1 cycle after. After reset the previous pattern counts as 1111.
- R11: Clearing cfg_en returns cs_n to all ones, SCLK to its idle level and idle to 1 at the next edge. frm_start is ignored while cfg_en is low.
- R12: idle is 1 only when no frame is active and all gaps have run out. It is never 1 while any chip select is low.
- R13: After reset, cs_n is 1111, SCLK is 0, both strobes are 0 and idle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Block enable; low forces the outputs inactive |
| cfg_cpol | input | 1 | Idle SCLK level |
| cfg_cpha | input | 1 | Selects which edge samples data |
| cfg_decode | input | 1 | 1: raw select field to pins; 0: one-hot from index |
| cfg_baud | input | 4 | Divider field N; SCLK = clk / 2(N+1) |
| cfg_csel | input | 4 | Raw select pattern or device index |
| cfg_lead | input | 8 | Delay from CS assert to first edge |
| cfg_tail | input | 8 | Delay from last edge to CS deassert |
| cfg_gap | input | 8 | Minimum CS-high time between frames |
| cfg_swap | input | 8 | Extra delay when the target device changes |
| frm_start | input | 1 | Frame start request |
| frm_stop | input | 1 | Frame stop request |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip selects |
| shift_stb | output | 1 | Launch-next-bit strobe |
| sample_stb | output | 1 | Capture-bit strobe |
| idle | output | 1 | No frame active and all gaps expired |

## Verification
The hardest cases to reach from the ports are the ones where one request meets another part of the timing. One is a stop request that arrives partway through an 8-bit unit, which must still give a whole number of units. The other is back-to-back frames, where the minimum CS-high time is the only thing holding off the next assertion. The bench drives stop a chosen number of SCLK transitions into the frame, both early and late in the first unit. It holds both start and stop high across two frames to the same device, so the gap alone separates them. Select patterns change between some frames and not others, so the device-switch delay is seen both inserted and skipped.

// File: rtl/sclk_cs_pkg.sv
package sclk_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWAP,
    ST_LEAD,
    ST_RUN,
    ST_TAIL,
    ST_GAP
  } seq_st_t;
endpackage

// File: rtl/cs_pattern.sv
module cs_pattern #(
  parameter int NCS = 4
) (
  input  logic           decode,
  input  logic [NCS-1:0] sel,
  output logic [NCS-1:0] pat
);
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1;

  logic [NCS-1:0] onehot_n;

  genvar k;
  generate
    for (k = 0; k < NCS; k++) begin : g_lane
      // lane k goes low only when the index selects it
      assign onehot_n[k] = (sel[SEL_W-1:0] != SEL_W'(k));
    end
  endgenerate

  assign pat = decode ? sel : onehot_n;
endmodule

// File: rtl/half_tick.sv
module half_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/sclk_cs_gen.sv
module sclk_cs_gen
  import sclk_cs_pkg::*;
#(
  parameter int BAUD_W    = 4,
  parameter int DLY_W     = 8,
  parameter int NCS       = 4,
  parameter int UNIT_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_decode,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic [NCS-1:0]    cfg_csel,
  input  logic [DLY_W-1:0]  cfg_lead,
  input  logic [DLY_W-1:0]  cfg_tail,
  input  logic [DLY_W-1:0]  cfg_gap,
  input  logic [DLY_W-1:0]  cfg_swap,
  input  logic              frm_start,
  input  logic              frm_stop,
  output logic              sclk,
  output logic [NCS-1:0]    cs_n,
  output logic              shift_stb,
  output logic              sample_stb,
  output logic              idle
);
  localparam int TMR_W = DLY_W + BAUD_W + 2;
  localparam int BIT_W = (UNIT_BITS > 1) ? $clog2(UNIT_BITS) : 1;

  seq_st_t        st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic           ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic           stop_q, stop_d;
  logic [NCS-1:0] pat_q, pat_d, last_q, last_d, pat_now;
  logic           tick, lead_e, trail_e, run;
  logic [TMR_W-1:0] half_w, tail_ld, gap_ld;

  assign half_w  = TMR_W'(cfg_baud) + TMR_W'(1);
  // built-in extras: one SCLK period plus three (tail) or one (gap) cycles
  assign tail_ld = TMR_W'(cfg_tail) + (half_w << 1) + TMR_W'(2);
  assign gap_ld  = TMR_W'(cfg_gap) + (half_w << 1) - TMR_W'(1);
  assign run     = cfg_en && (st_q == ST_RUN);

  cs_pattern #(.NCS(NCS)) u_pat (
    .decode (cfg_decode),
    .sel    (cfg_csel),
    .pat    (pat_now)
  );

  half_tick #(.W(BAUD_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (cfg_baud),
    .tick (tick)
  );

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    stop_d  = stop_q;
    pat_d   = pat_q;
    last_d  = last_q;
    lead_e  = 1'b0;
    trail_e = 1'b0;
    if (!cfg_en) begin
      st_d   = ST_IDLE;
      tmr_d  = '0;
      ph_d   = 1'b0;
      bit_d  = '0;
      stop_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (frm_start) begin
            pat_d  = pat_now;
            last_d = pat_now;
            stop_d = 1'b0;
            if (pat_now != last_q) begin
              st_d  = ST_SWAP;
              tmr_d = TMR_W'(cfg_swap);
            end else begin
              st_d  = ST_LEAD;
              tmr_d = TMR_W'(cfg_lead);
            end
          end
        end
        ST_SWAP: begin
          if (tmr_q == '0) begin
            st_d  = ST_LEAD;
            tmr_d = TMR_W'(cfg_lead);
          end else tmr_d = tmr_q - TMR_W'(1);
        end
        ST_LEAD: begin
          stop_d = stop_q | frm_stop;
          if (tmr_q == '0) begin
            st_d  = ST_RUN;
            ph_d  = 1'b0;
            bit_d = '0;
          end else tmr_d = tmr_q - TMR_W'(1);
        end
        ST_RUN: begin
          stop_d = stop_q | frm_stop;
          if (tick) begin
            ph_d = ~ph_q;
            if (!ph_q) lead_e = 1'b1;
            else begin
              trail_e = 1'b1;
              if (bit_q == BIT_W'(UNIT_BITS - 1)) begin
                bit_d = '0;
                if (stop_d) begin
                  st_d   = ST_TAIL;
                  tmr_d  = tail_ld;
                  stop_d = 1'b0;
                end
              end else bit_d = bit_q + BIT_W'(1);
            end
          end
        end
        ST_TAIL: begin
          if (tmr_q == '0) begin
            st_d  = ST_GAP;
            tmr_d = gap_ld;
          end else tmr_d = tmr_q - TMR_W'(1);
        end
        ST_GAP: begin
          if (tmr_q == '0) st_d = ST_IDLE;
          else             tmr_d = tmr_q - TMR_W'(1);
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      tmr_q      <= '0;
      ph_q       <= 1'b0;
      bit_q      <= '0;
      stop_q     <= 1'b0;
      pat_q      <= '1;
      last_q     <= '1;
      sclk       <= 1'b0;
      cs_n       <= '1;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
      idle       <= 1'b1;
    end else begin
      st_q       <= st_d;
      tmr_q      <= tmr_d;
      ph_q       <= ph_d;
      bit_q      <= bit_d;
      stop_q     <= stop_d;
      pat_q      <= pat_d;
      last_q     <= last_d;
      sclk       <= cfg_cpol ^ ph_d;
      cs_n       <= (st_d == ST_LEAD || st_d == ST_RUN || st_d == ST_TAIL) ? pat_d : '1;
      sample_stb <= (lead_e & ~cfg_cpha) | (trail_e & cfg_cpha);
      shift_stb  <= (lead_e & cfg_cpha) | (trail_e & ~cfg_cpha);
      idle       <= (st_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/sclk_cs_chk.sv
module sclk_cs_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_en,
  input logic           cfg_cpol,
  input logic           cfg_decode,
  input logic           sclk,
  input logic [NCS-1:0] cs_n,
  input logic           shift_stb,
  input logic           sample_stb,
  input logic           idle
);
  // R2: SCLK parks at the polarity level while no device is selected
  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (&cs_n) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

  // R3: a strobe only accompanies a visible SCLK transition
  a_r3_strobe_edge: assert property (@(posedge clk) disable iff (rst)
    (shift_stb || sample_stb) |-> (sclk != $past(sclk)));

  // R3: strobes only inside an active frame
  a_r3_strobe_active: assert property (@(posedge clk) disable iff (rst)
    (shift_stb || sample_stb) |-> !(&cs_n));

  // R5: one-hot mode never selects more than one device
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    !cfg_decode |-> ($countones(~cs_n) <= 1));

  // R11: dropping enable releases every select and reports idle
  a_r11_disable: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> ((&cs_n) && idle));

  // R12: idle excludes any selected device or strobe
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    idle |-> ((&cs_n) && !shift_stb && !sample_stb));
endmodule

bind sclk_cs_gen sclk_cs_chk #(.NCS(NCS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_en     (cfg_en),
  .cfg_cpol   (cfg_cpol),
  .cfg_decode (cfg_decode),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .shift_stb  (shift_stb),
  .sample_stb (sample_stb),
  .idle       (idle)
);

// File: tb/sim_sclk_cs_gen.sv
`timescale 1ns/1ps
module sim_sclk_cs_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_decode = 1'b0;
  logic [3:0] cfg_baud = '0, cfg_csel = '0;
  logic [7:0] cfg_lead = '0, cfg_tail = '0, cfg_gap = '0, cfg_swap = '0;
  logic frm_start = 1'b0, frm_stop = 1'b0;
  logic sclk, shift_stb, sample_stb, idle;
  logic [3:0] cs_n;

  always #10 clk = ~clk;

  sclk_cs_gen u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_decode(cfg_decode), .cfg_baud(cfg_baud), .cfg_csel(cfg_csel),
    .cfg_lead(cfg_lead), .cfg_tail(cfg_tail), .cfg_gap(cfg_gap), .cfg_swap(cfg_swap),
    .frm_start(frm_start), .frm_stop(frm_stop), .sclk(sclk), .cs_n(cs_n),
    .shift_stb(shift_stb), .sample_stb(sample_stb), .idle(idle)
  );

  int n_chk = 0, n_bad = 0, wd = 0;
  logic [3:0] last_pat = 4'hF;

  // event monitor, sampled on the falling edge
  logic mon_clr = 1'b0;
  int cyc = 0, t_req, t_as, t_first, t_last, t_de, t_idle, t_hi, nedge, sp_err, st_err, act_err;
  logic req_seen, de_seen, idle_seen, hi_seen, sclk_p = 1'b0, idle_p = 1'b1, ld, es;
  logic [3:0] csn_p = 4'hF, pat_seen;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      req_seen = 0; de_seen = 0; idle_seen = 0; hi_seen = 0;
      nedge = 0; sp_err = 0; st_err = 0; act_err = 0;
      t_req = 0; t_as = 0; t_first = 0; t_last = 0; t_de = 0; t_idle = 0; t_hi = 0;
      pat_seen = 4'hF;
    end else begin
      if (frm_start && !req_seen) begin req_seen = 1; t_req = cyc; end
      if ((&csn_p) && !(&cs_n)) begin
        if (de_seen && !hi_seen) begin hi_seen = 1; t_hi = cyc - t_de; end
        t_as = cyc; pat_seen = cs_n;
      end
      if (!(&csn_p) && (&cs_n) && !de_seen) begin de_seen = 1; t_de = cyc; end
      if (idle && !idle_p && de_seen && !idle_seen) begin idle_seen = 1; t_idle = cyc; end
      if (sclk != sclk_p) begin
        if (nedge > 0 && (cyc - t_last) != int'(cfg_baud) + 1) sp_err++;
        if (nedge == 0) t_first = cyc;
        t_last = cyc;
        nedge++;
        ld = (sclk != cfg_cpol);
        es = ld ^ cfg_cpha;
        if (sample_stb != es || shift_stb != !es) st_err++;
      end else if (shift_stb || sample_stb) st_err++;
      if (idle && !(&cs_n)) act_err++;
    end
    sclk_p = sclk; csn_p = cs_n; idle_p = idle;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1; step(1); mon_clr = 1'b0;
  endtask

  task automatic setup(input int b, input bit cp, input bit ph, input bit dec, input logic [3:0] fld,
                       input int lead, input int tail, input int gap, input int sw);
    cfg_en = 1'b0; step(1);
    cfg_baud = 4'(b); cfg_cpol = cp; cfg_cpha = ph; cfg_decode = dec; cfg_csel = fld;
    cfg_lead = 8'(lead); cfg_tail = 8'(tail); cfg_gap = 8'(gap); cfg_swap = 8'(sw);
    step(3); cfg_en = 1'b1; step(1);
    clear_mon();
  endtask

  function automatic logic [3:0] exp_pattern(input bit dec, input logic [3:0] fld);
    return dec ? fld : (~(4'b0001 << fld[1:0]));
  endfunction

  task automatic frame(input int b, input bit cp, input bit ph, input bit dec, input logic [3:0] fld,
                       input int lead, input int tail, input int gap, input int sw, input int stop_after);
    logic [3:0] ep;
    bit swp;
    int units;
    ep = exp_pattern(dec, fld);
    swp = (ep != last_pat);
    last_pat = ep;
    units = stop_after / 16 + 1;
    setup(b, cp, ph, dec, fld, lead, tail, gap, sw);
    frm_start = 1'b1; step(1); frm_start = 1'b0;
    while (nedge < stop_after) step(1);
    frm_stop = 1'b1; step(1); frm_stop = 1'b0;
    while (!idle_seen) step(1);
    step(1);
    chk(dec ? "R4 raw select" : "R5 one-hot select", int'(pat_seen), int'(ep));
    chk("R10 start to assert", t_as - t_req, swp ? sw + 2 : 1);
    chk("R6 lead", t_first - t_as, lead + b + 2);
    chk("R9 whole units", nedge, 16 * units);
    chk("R1 edge spacing", sp_err, 0);
    chk("R3 strobes", st_err, 0);
    chk("R7 tail", t_de - t_last, tail + 2 * (b + 1) + 3);
    chk("R8 gap to idle", t_idle - t_de, gap + 2 * (b + 1));
    chk("R12 idle vs select", act_err, 0);
    chk("R2 idle level", int'(sclk), int'(cp));
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    // R13 reset values
    chk("R13 cs_n", int'(cs_n), 15);
    chk("R13 sclk", int'(sclk), 0);
    chk("R13 strobes", int'(shift_stb) + int'(sample_stb), 0);
    chk("R13 idle", int'(idle), 1);
    rst = 1'b0; step(2);

    // sweep divider, mode and selection
    for (int b = 0; b < 4; b++) begin
      for (int m = 0; m < 4; m++) begin
        frame(b, m[1], m[0], (m == 3), (m == 3) ? (4'hA ^ 4'(b)) : 4'((b + m) % 4),
              b * 3 + m, m * 2 + 1, b + m, 2 + m, 3);
      end
    end
    // same device again: switch delay skipped (R10); stop late in first unit (R9)
    frame(1, 0, 1, 0, 4'd0, 4, 2, 3, 9, 14);
    // multi-unit frames (R9)
    frame(2, 1, 0, 0, 4'd1, 2, 0, 1, 5, 19);
    frame(0, 0, 0, 0, 4'd1, 0, 0, 0, 0, 17);
    // long delays
    frame(3, 1, 1, 0, 4'd2, 200, 150, 100, 40, 3);

    // back-to-back frames, start and stop held (R8)
    setup(1, 0, 0, 0, 4'd2, 1, 0, 5, 0);
    last_pat = exp_pattern(0, 4'd2);
    frm_start = 1'b1; frm_stop = 1'b1;
    while (!hi_seen) step(1);
    frm_start = 1'b0;
    step(1);
    while (!idle) step(1);
    frm_stop = 1'b0;
    chk("R8 min high between frames", t_hi, 5 + 2 * 2 + 1);
    chk("R3 strobes back-to-back", st_err, 0);

    // enable drop mid-frame (R11)
    setup(2, 1, 0, 0, 4'd3, 1, 1, 1, 0);
    last_pat = exp_pattern(0, 4'd3);
    frm_start = 1'b1; step(1); frm_start = 1'b0;
    while (nedge < 4) step(1);
    cfg_en = 1'b0; step(1);
    chk("R11 cs released", int'(cs_n), 15);
    chk("R11 sclk idle", int'(sclk), 1);
    chk("R11 idle", int'(idle), 1);
    frm_start = 1'b1; step(1); frm_start = 1'b0; step(5);
    chk("R11 start ignored when disabled", int'(cs_n), 15);
    chk("R11 no strobes when disabled", int'(shift_stb) + int'(sample_stb), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule